// File: doc/BRIEF.md
# Sector Sub-block Host Transfer Sequencer

This block walks one buffered sector out toward the host side as a series of up to three sub-blocks. Each sub-block is described by an enable, a send condition, a start offset into the sector buffer, a programmed length and an automatic-length select. A start pulse captures the sector's Form bit, its Mode 2 flag and the whole sub-block configuration. The block then issues one buffer read address per cycle while the host side signals ready. Each address is tagged with the index of the sub-block it belongs to.

Sub-blocks are visited in fixed index order. One whose condition does not match the captured Form bit is skipped, and so is one whose effective length is zero. For Mode 2 sectors a sub-block can take its length from the Form bit instead of its register. The pointers are reloaded from the programmed offsets on every start, so firmware programs the layout once and fires one start per sector. A one-cycle done pulse closes each sector. A start that arrives while a sector is in flight is dropped.

Top module: `sector_subblock_seq`

## Requirements
- R1: While reset is high and in the first cycle after it falls, `rd_valid`, `done` and `busy` are 0.
- R2: Sub-blocks are transferred in ascending index order, each as one contiguous run. Within a run, `rd_addr` goes from the sub-block's start offset upward by 1 per word, wrapping modulo 2^ADDR_W. `rd_sub` carries the index.
- R3: A sub-block is sent only if its enable bit is 1 and its 2-bit condition field matches the captured Form bit. The field values are: 2'b00 sends when Form = 0, 2'b01 sends when Form = 1, and 2'b10 or 2'b11 sends regardless of Form (unconditional).
- R4: The word count of a sub-block depends on its automatic-length bit. If that bit is 1 and Mode 2 is captured, the count is 2048 for Form = 0 and 2324 for Form = 1. Otherwise it is the programmed length. A sub-block whose count is 0 is skipped.
- R5: `rd_valid` is high in a cycle only if `host_rdy` was high in the previous cycle. With `host_rdy` held high, the words of one sub-block come out on consecutive cycles.
- R6: `done` is a single-cycle pulse. It is high in the cycle right after the last word of the sector. If nothing is to be sent, it is high two cycles after the cycle in which `start` was sampled.
- R7: `start` is acted on only when the block is idle. A start during a transfer has no effect. Configuration, Form and Mode 2 changes made after the accepted start do not alter that sector's stream.
- R8: Every accepted start reloads the pointers from the programmed offsets, so the same configuration yields the same address stream sector after sector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin one sector (ignored when busy) |
| form_bit | input | 1 | Sector Form bit, captured at start |
| mode2 | input | 1 | Sector is Mode 2, captured at start |
| host_rdy | input | 1 | Host side can take a word this cycle |
| sb_en | input | NUM_SUB | Per-sub-block enable |
| sb_cond | input | 2*NUM_SUB | Per-sub-block send condition |
| sb_auto | input | NUM_SUB | Per-sub-block automatic Mode 2 length |
| sb_start | input | ADDR_W*NUM_SUB | Per-sub-block start offset |
| sb_len | input | LEN_W*NUM_SUB | Per-sub-block programmed length |
| rd_valid | output | 1 | Buffer read address valid |
| rd_addr | output | ADDR_W | Buffer read address |
| rd_sub | output | IDX_W | Sub-block index of the current word |
| done | output | 1 | Sector complete pulse |
| busy | output | 1 | A sector is in progress |

## Verification
The bench builds the block with its defaults: three sub-blocks, a 12-bit offset and a 12-bit length. These values let it reach the full 2048- and 2324-word automatic lengths, and a start offset near 4095 drives the address through its wrap. Random Form, condition, enable and length settings are mixed with a stalling ready signal. Directed sectors cover the all-skipped case, zero lengths, a start fired mid-transfer while the configuration changes, and a repeated sector.

// File: rtl/sbseq_pkg.sv
package sbseq_pkg;

  typedef enum logic [1:0] {
    COND_FORM0  = 2'b00,
    COND_FORM1  = 2'b01,
    COND_ALWAYS = 2'b10,
    COND_FORCE  = 2'b11
  } sb_cond_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_SEL  = 2'b01,
    ST_XFER = 2'b10
  } seq_state_e;

endpackage

// File: rtl/sbseq_eligibility.sv
module sbseq_eligibility
  import sbseq_pkg::*;
#(
  parameter int NUM_SUB = 3,
  parameter int LEN_W   = 12,
  parameter int F0_LEN  = 2048,
  parameter int F1_LEN  = 2324
) (
  input  logic [NUM_SUB-1:0]       en,
  input  logic [2*NUM_SUB-1:0]     cond,
  input  logic [NUM_SUB-1:0]       auto_len,
  input  logic [LEN_W*NUM_SUB-1:0] len,
  input  logic                     form_bit,
  input  logic                     mode2,
  output logic [NUM_SUB-1:0]       send_mask,
  output logic [LEN_W*NUM_SUB-1:0] eff_len
);

  for (genvar i = 0; i < NUM_SUB; i++) begin : g_sub
    sb_cond_e   c;
    logic       cond_ok;
    logic [LEN_W-1:0] l;

    assign c = sb_cond_e'(cond[2*i +: 2]);

    always_comb begin
      case (c)
        COND_FORM0: cond_ok = ~form_bit;
        COND_FORM1: cond_ok = form_bit;
        default:    cond_ok = 1'b1;
      endcase
    end

    always_comb begin
      if (auto_len[i] && mode2)
        l = form_bit ? LEN_W'(F1_LEN) : LEN_W'(F0_LEN);
      else
        l = len[LEN_W*i +: LEN_W];
    end

    assign eff_len[LEN_W*i +: LEN_W] = l;
    assign send_mask[i] = en[i] && cond_ok && (l != '0);
  end

endmodule

// File: rtl/sbseq_picker.sv
module sbseq_picker #(
  parameter int NUM_SUB = 3,
  parameter int IDX_W   = 2
) (
  input  logic [NUM_SUB-1:0] mask,
  output logic               any,
  output logic [IDX_W-1:0]   idx
);

  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = NUM_SUB - 1; i >= 0; i--) begin
      if (mask[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/sbseq_addr_gen.sv
module sbseq_addr_gen #(
  parameter int ADDR_W = 12,
  parameter int LEN_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [LEN_W-1:0]  load_len,
  input  logic              step,
  output logic [ADDR_W-1:0] addr,
  output logic              last
);

  logic [LEN_W-1:0] rem;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr <= '0;
      rem  <= '0;
    end else if (load) begin
      addr <= load_addr;
      rem  <= load_len;
    end else if (step) begin
      addr <= addr + ADDR_W'(1);
      rem  <= rem - LEN_W'(1);
    end
  end

  assign last = (rem == LEN_W'(1));

endmodule

// File: rtl/sector_subblock_seq.sv
module sector_subblock_seq
  import sbseq_pkg::*;
#(
  parameter int NUM_SUB = 3,
  parameter int ADDR_W  = 12,
  parameter int LEN_W   = 12,
  parameter int F0_LEN  = 2048,
  parameter int F1_LEN  = 2324,
  localparam int IDX_W  = (NUM_SUB > 1) ? $clog2(NUM_SUB) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  input  logic                      form_bit,
  input  logic                      mode2,
  input  logic                      host_rdy,
  input  logic [NUM_SUB-1:0]        sb_en,
  input  logic [2*NUM_SUB-1:0]      sb_cond,
  input  logic [NUM_SUB-1:0]        sb_auto,
  input  logic [ADDR_W*NUM_SUB-1:0] sb_start,
  input  logic [LEN_W*NUM_SUB-1:0]  sb_len,
  output logic                      rd_valid,
  output logic [ADDR_W-1:0]         rd_addr,
  output logic [IDX_W-1:0]          rd_sub,
  output logic                      done,
  output logic                      busy
);

  seq_state_e state;

  logic [NUM_SUB-1:0]        send_mask;
  logic [LEN_W*NUM_SUB-1:0]  eff_len;
  logic [NUM_SUB-1:0]        pend;
  logic [LEN_W*NUM_SUB-1:0]  len_q;
  logic [ADDR_W*NUM_SUB-1:0] start_q;
  logic [IDX_W-1:0]          cur;

  logic                      pick_any;
  logic [IDX_W-1:0]          pick_idx;

  logic                      ag_load;
  logic                      ag_step;
  logic [ADDR_W-1:0]         ag_addr;
  logic                      ag_last;

  sbseq_eligibility #(
    .NUM_SUB (NUM_SUB),
    .LEN_W   (LEN_W),
    .F0_LEN  (F0_LEN),
    .F1_LEN  (F1_LEN)
  ) u_elig (
    .en        (sb_en),
    .cond      (sb_cond),
    .auto_len  (sb_auto),
    .len       (sb_len),
    .form_bit  (form_bit),
    .mode2     (mode2),
    .send_mask (send_mask),
    .eff_len   (eff_len)
  );

  sbseq_picker #(
    .NUM_SUB (NUM_SUB),
    .IDX_W   (IDX_W)
  ) u_pick (
    .mask (pend),
    .any  (pick_any),
    .idx  (pick_idx)
  );

  assign ag_load = (state == ST_SEL) && pick_any;
  assign ag_step = (state == ST_XFER) && host_rdy;

  sbseq_addr_gen #(
    .ADDR_W (ADDR_W),
    .LEN_W  (LEN_W)
  ) u_agen (
    .clk       (clk),
    .rst       (rst),
    .load      (ag_load),
    .load_addr (start_q[ADDR_W*pick_idx +: ADDR_W]),
    .load_len  (len_q[LEN_W*pick_idx +: LEN_W]),
    .step      (ag_step),
    .addr      (ag_addr),
    .last      (ag_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      pend     <= '0;
      len_q    <= '0;
      start_q  <= '0;
      cur      <= '0;
      rd_valid <= 1'b0;
      rd_addr  <= '0;
      rd_sub   <= '0;
      done     <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      done     <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            pend    <= send_mask;
            len_q   <= eff_len;
            start_q <= sb_start;
            state   <= ST_SEL;
          end
        end
        ST_SEL: begin
          if (pick_any) begin
            cur            <= pick_idx;
            pend[pick_idx] <= 1'b0;
            state          <= ST_XFER;
          end else begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end
        end
        ST_XFER: begin
          if (host_rdy) begin
            rd_valid <= 1'b1;
            rd_addr  <= ag_addr;
            rd_sub   <= cur;
            if (ag_last) state <= ST_SEL;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/sector_subblock_seq_chk.sv
module sector_subblock_seq_chk #(
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              host_rdy,
  input logic              rd_valid,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [IDX_W-1:0]  rd_sub,
  input logic              done,
  input logic              busy
);

  AST_VALID_AFTER_RDY: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(host_rdy)); // R5

  AST_VALID_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> busy); // R5

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && $past(rd_valid) && rd_sub == $past(rd_sub))
      |-> rd_addr == $past(rd_addr) + ADDR_W'(1)); // R2

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R6

  AST_DONE_NO_DATA: assert property (@(posedge clk) disable iff (rst)
    done |-> !rd_valid && !busy); // R6

  AST_DONE_FROM_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(busy)); // R6

endmodule

bind sector_subblock_seq sector_subblock_seq_chk #(
  .ADDR_W (ADDR_W),
  .IDX_W  (IDX_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .host_rdy (host_rdy),
  .rd_valid (rd_valid),
  .rd_addr  (rd_addr),
  .rd_sub   (rd_sub),
  .done     (done),
  .busy     (busy)
);

// File: tb/sector_subblock_seq_test.sv
module sector_subblock_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int NS = 3;
  localparam int AW = 12;
  localparam int LW = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic form_bit = 1'b0;
  logic mode2 = 1'b0;
  logic host_rdy = 1'b0;
  logic [NS-1:0]    sb_en = '0;
  logic [2*NS-1:0]  sb_cond = '0;
  logic [NS-1:0]    sb_auto = '0;
  logic [AW*NS-1:0] sb_start = '0;
  logic [LW*NS-1:0] sb_len = '0;
  logic             rd_valid;
  logic [AW-1:0]    rd_addr;
  logic [1:0]       rd_sub;
  logic             done;
  logic             busy;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int seed_dummy;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sector_subblock_seq uut (
    .clk(clk), .rst(rst), .start(start), .form_bit(form_bit), .mode2(mode2),
    .host_rdy(host_rdy), .sb_en(sb_en), .sb_cond(sb_cond), .sb_auto(sb_auto),
    .sb_start(sb_start), .sb_len(sb_len), .rd_valid(rd_valid), .rd_addr(rd_addr),
    .rd_sub(rd_sub), .done(done), .busy(busy)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  task automatic set_sub(input int i, input bit e, input bit [1:0] c, input bit a,
                         input bit [AW-1:0] s, input bit [LW-1:0] l);
    sb_en[i] = e;
    sb_cond[2*i +: 2] = c;
    sb_auto[i] = a;
    sb_start[AW*i +: AW] = s;
    sb_len[LW*i +: LW] = l;
  endtask

  // R4: effective word count of a sub-block
  function automatic int exp_len(input int i);
    if (sb_auto[i] && mode2) return form_bit ? 2324 : 2048;
    return int'(sb_len[LW*i +: LW]);
  endfunction

  // R3: send decision from enable and condition field
  function automatic bit exp_send(input int i);
    bit ok;
    case (sb_cond[2*i +: 2])
      2'b00: ok = !form_bit;
      2'b01: ok = form_bit;
      default: ok = 1'b1;
    endcase
    return sb_en[i] && ok && exp_len(i) != 0;
  endfunction

  // Runs one sector. rnd: random ready stalls. poke: restart mid-transfer with new config.
  task automatic run_sector(input string tag, input bit rnd, input bit poke);
    int e_sub[$];
    int e_addr[$];
    int a_sub[$];
    int a_addr[$];
    int a_cyc[$];
    int s_cyc, d_cyc, k;
    bit got_done;
    for (int i = 0; i < NS; i++)
      if (exp_send(i))
        for (int w = 0; w < exp_len(i); w++) begin
          e_sub.push_back(i);
          e_addr.push_back((int'(sb_start[AW*i +: AW]) + w) % (1 << AW));
        end
    s_cyc = cyc;
    start = 1'b1;
    host_rdy = rnd ? ($urandom % 4 != 0) : 1'b1;
    got_done = 1'b0;
    d_cyc = 0;
    k = 0;
    while (!got_done && k < 20000) begin
      @(negedge clk);
      start = 1'b0;
      if (rd_valid) begin
        a_sub.push_back(int'(rd_sub));
        a_addr.push_back(int'(rd_addr));
        a_cyc.push_back(cyc);
      end
      if (done) begin
        got_done = 1'b1;
        d_cyc = cyc;
      end
      if (poke && k == 6) begin
        // R7: changes and restart after acceptance must not matter
        form_bit = ~form_bit;
        mode2 = ~mode2;
        sb_en = '1;
        sb_cond = '1;
        sb_len = {NS{12'd9}};
        sb_start = {NS{12'd100}};
        start = 1'b1;
      end
      host_rdy = rnd ? ($urandom % 4 != 0) : 1'b1;
      k++;
    end
    start = 1'b0;
    check({tag, " R6 done seen"}, int'(got_done), 1);
    check({tag, " R2 word count"}, a_sub.size(), e_sub.size());
    for (int w = 0; w < e_sub.size() && w < a_sub.size(); w++) begin
      check({tag, " R3 sub index"}, a_sub[w], e_sub[w]);
      check({tag, " R2 address"}, a_addr[w], e_addr[w]);
      if (!rnd && w > 0 && a_sub[w] == a_sub[w-1])
        check({tag, " R5 back-to-back"}, a_cyc[w], a_cyc[w-1] + 1);
    end
    if (a_cyc.size() > 0)
      check({tag, " R6 done after last word"}, d_cyc, a_cyc[a_cyc.size()-1] + 1);
    else
      check({tag, " R6 done with nothing to send"}, d_cyc, s_cyc + 2);
    host_rdy = 1'b1;
    for (int q = 0; q < 4; q++) begin
      @(negedge clk);
      check({tag, " R7 quiet after done"}, int'(rd_valid || busy || done), 0);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    seed_dummy = $urandom(20240611);
    repeat (3) @(negedge clk);
    check("R1 valid in reset", int'(rd_valid), 0);
    check("R1 done in reset", int'(done), 0);
    check("R1 busy in reset", int'(busy), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 valid after reset", int'(rd_valid), 0);
    check("R1 busy after reset", int'(busy), 0);

    // R2/R5: all unconditional, ready held high
    set_sub(0, 1, 2'b10, 0, 12'd10, 12'd3);
    set_sub(1, 1, 2'b11, 0, 12'd200, 12'd4);
    set_sub(2, 1, 2'b10, 0, 12'd50, 12'd5);
    run_sector("all-always", 0, 0);

    // R3: form-dependent selection
    set_sub(0, 1, 2'b00, 0, 12'd0, 12'd4);
    set_sub(1, 1, 2'b01, 0, 12'd300, 12'd4);
    set_sub(2, 1, 2'b10, 0, 12'd600, 12'd2);
    form_bit = 1'b0; run_sector("form0", 0, 0);
    form_bit = 1'b1; run_sector("form1", 0, 0);
    sb_en[2] = 1'b0; run_sector("disabled", 0, 0);

    // R4: automatic length and zero length
    set_sub(0, 1, 2'b10, 1, 12'd16, 12'd7);
    set_sub(1, 1, 2'b10, 0, 12'd0, 12'd0);
    set_sub(2, 0, 2'b10, 0, 12'd0, 12'd3);
    mode2 = 1'b1; form_bit = 1'b0; run_sector("auto form0", 0, 0);
    form_bit = 1'b1; run_sector("auto form1", 1, 0);
    mode2 = 1'b0; run_sector("auto not mode2", 0, 0);

    // R6: nothing to send
    sb_en = '0;
    run_sector("empty", 0, 0);

    // R2: address wrap
    set_sub(0, 1, 2'b10, 0, 12'd4093, 12'd6);
    set_sub(1, 0, 2'b10, 0, 12'd0, 12'd1);
    set_sub(2, 1, 2'b01, 0, 12'd4095, 12'd2);
    form_bit = 1'b1;
    run_sector("wrap", 0, 0);

    // R7: restart mid-transfer
    form_bit = 1'b0; mode2 = 1'b0;
    set_sub(0, 1, 2'b00, 0, 12'd40, 12'd12);
    set_sub(1, 1, 2'b01, 0, 12'd80, 12'd5);
    set_sub(2, 1, 2'b10, 0, 12'd120, 12'd6);
    run_sector("restart ignored", 0, 1);

    // R8: same configuration twice reproduces the stream
    form_bit = 1'b0; mode2 = 1'b0;
    set_sub(0, 1, 2'b00, 0, 12'd40, 12'd12);
    set_sub(1, 1, 2'b01, 0, 12'd80, 12'd5);
    set_sub(2, 1, 2'b10, 0, 12'd120, 12'd6);
    run_sector("reload pass1", 1, 0);
    run_sector("reload pass2", 1, 0);

    // random sectors
    for (int n = 0; n < 40; n++) begin
      form_bit = 1'($urandom);
      mode2 = ($urandom % 8 == 0);
      for (int i = 0; i < NS; i++)
        set_sub(i, ($urandom % 5 != 0), 2'($urandom), ($urandom % 6 == 0),
                12'($urandom), 12'($urandom % 24));
      run_sector("random", 1, 0);
    end

    finish_run();
  end

endmodule